// File: doc/BRIEF.md
# Supply Monitor Control and Status Registers

This block is the digital side of a supply monitor. Two comparator levels arrive from the analog front end: one says the supply has dropped under the detect threshold, the other says it has dropped under the warning threshold. For each, the block holds a sticky event flag that software clears by writing a one to an acknowledge bit, and it raises a level interrupt when the flag and its enable are both set. The detect side can also raise a reset request to the reset controller. The threshold select codes go out to the analog side. A third byte covers the regulator: a bandgap buffer enable, a bandgap-in-low-power enable, a read-only run-regulation status, and an I/O isolation latch that is set on exit from deep low-leakage mode and released by software.

Software reaches the three bytes over a simple synchronous bus. Writes take effect on the clock edge where the write strobe is high, and read data is a combinational function of the address. There are two reset inputs. The power-on reset clears everything. The chip reset clears everything except the two threshold select codes, so a configured threshold survives a warm reset.

Top module: `lvd_ctrl_regs`

## Requirements
- R1: After power-on reset, with both comparators inactive and the regulator status input high, byte 0 reads 0x10, byte 1 reads 0x00, byte 2 reads 0x04, and all interrupt, reset-request and isolation outputs are low.
- R2: Detect byte bit 4 is the reset enable. Only the first write to byte 0 after a reset changes it. Later writes leave it unchanged until the next reset.
- R3: Writing 1 to bit 6 of byte 0 clears the detect flag (bit 7), and writing 1 to bit 6 of byte 1 clears the warning flag (bit 7). Bit 6 always reads as 0.
- R4: The reset request is high while the detect flag and the reset enable are both 1. Each interrupt is high while its flag and its enable (bit 5 of its byte) are both 1.
- R5: The threshold selects (bits 1:0 of bytes 0 and 1, driven on the trip-select outputs) keep their values through a chip reset and clear only on a power-on reset.
- R6: A flag sets on the cycle after its comparator input goes from 0 to 1. A comparator that is already high when a reset ends counts as such a transition. A comparator that simply stays high does not set the flag again after an acknowledge.
- R7: While the low-power mode input is high, no flag can set. A transition that happens during that time is not remembered afterwards.
- R8: Byte 2 has buffer enable at bit 0, regulator run status at bit 2 (a copy of the status input), isolation at bit 3, and bandgap low-power enable at bit 4. Bits 0 and 4 are writable and drive their outputs.
- R9: A pulse on the isolation set input sets the isolation flag and the isolation output. Writing byte 2 with bit 3 set clears the flag. A write with bit 3 clear leaves it set.
- R10: If a flag-setting comparator transition and an acknowledge write for the same flag happen in the same cycle, the flag ends up set.
- R11: Reserved bits (byte 0 bits 3:2, byte 1 bits 4:2, byte 2 bits 1 and 7:5) read as 0 whatever is written, and address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| chip_rst_n | input | 1 | Chip reset, active low, asynchronous; leaves trip selects alone |
| bus_addr | input | 2 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| det_below | input | 1 | Supply is under the detect threshold |
| warn_below | input | 1 | Supply is under the warning threshold |
| lowpwr_mode | input | 1 | Low-power or low-leakage mode active; detection off |
| reg_run_stat | input | 1 | Regulator is in run regulation |
| iso_set | input | 1 | Pulse on exit from deep low-leakage mode |
| det_trip_sel | output | 2 | Detect threshold select |
| warn_trip_sel | output | 2 | Warning threshold select |
| det_irq | output | 1 | Detect interrupt |
| warn_irq | output | 1 | Warning interrupt |
| lvd_reset_req | output | 1 | Reset request to the reset controller |
| bgbuf_en | output | 1 | Bandgap buffer enable |
| bg_lp_en | output | 1 | Bandgap enable in low-power modes |
| io_iso | output | 1 | I/O isolation held |

## Verification
On every cycle the checker confirms that a locked reset enable stays fixed, that an acknowledge with no new event clears its flag, that low-power mode keeps a clear flag clear, that an isolation pulse always leaves isolation set, and that an interrupt is never high without its enable. The threshold values kept across a chip reset, the level-sampled flag set when a reset ends, the same-cycle event-and-acknowledge race, the reserved-bit readback and the exact reset byte values can only be shown by the bench's scenarios. Those need reset sequences and bus reads, which the checker is disabled for or cannot predict.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_DET  = 2'd0;
    localparam logic [ADDR_W-1:0] A_WARN = 2'd1;
    localparam logic [ADDR_W-1:0] A_REG  = 2'd2;

    // bit positions shared by the detect and warning bytes
    localparam int B_IE   = 5;
    localparam int B_ACK  = 6;
    localparam int B_FLAG = 7;
    localparam int B_RE   = 4;
    // regulator byte
    localparam int B_BUF  = 0;
    localparam int B_RUN  = 2;
    localparam int B_ISO  = 3;
    localparam int B_BGLP = 4;

    localparam int NCH    = 2;   // channel 0 detect, channel 1 warning
    localparam int CH_DET = 0;
    localparam int CH_WRN = 1;

    typedef struct packed {
        logic       re;
        logic       re_locked;
        logic [1:0] ie;
        logic       bgbuf;
        logic       bglp;
        logic       iso;
    } chip_st_t;
endpackage

// File: rtl/lvd_flag_cell.sv
module lvd_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic below,
    input  logic block,
    input  logic ack,
    output logic flag
);
    typedef struct packed {
        logic prev;
        logic flag;
    } cell_st_t;

    cell_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = below;
        // prev resets to 0, so a level already low-supply at reset exit acts as an edge
        if (below && !st_q.prev && !block)
            st_d.flag = 1'b1;
        else if (ack)
            st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/lvd_readback.sv
module lvd_readback
    import lvd_pkg::*;
#(
    parameter int TRIP_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [TRIP_W-1:0] det_sel,
    input  logic [TRIP_W-1:0] warn_sel,
    input  logic [NCH-1:0]    flag,
    input  chip_st_t          st,
    input  logic              run_stat,
    output logic [BYTE_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        unique case (addr)
            A_DET: begin
                rdata[TRIP_W-1:0] = det_sel;
                rdata[B_RE]       = st.re;
                rdata[B_IE]       = st.ie[CH_DET];
                rdata[B_FLAG]     = flag[CH_DET];
            end
            A_WARN: begin
                rdata[TRIP_W-1:0] = warn_sel;
                rdata[B_IE]       = st.ie[CH_WRN];
                rdata[B_FLAG]     = flag[CH_WRN];
            end
            A_REG: begin
                rdata[B_BUF]  = st.bgbuf;
                rdata[B_RUN]  = run_stat;
                rdata[B_ISO]  = st.iso;
                rdata[B_BGLP] = st.bglp;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/lvd_ctrl_regs.sv
module lvd_ctrl_regs
    import lvd_pkg::*;
#(
    parameter int TRIP_W = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              chip_rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              det_below,
    input  logic              warn_below,
    input  logic              lowpwr_mode,
    input  logic              reg_run_stat,
    input  logic              iso_set,
    output logic [TRIP_W-1:0] det_trip_sel,
    output logic [TRIP_W-1:0] warn_trip_sel,
    output logic              det_irq,
    output logic              warn_irq,
    output logic              lvd_reset_req,
    output logic              bgbuf_en,
    output logic              bg_lp_en,
    output logic              io_iso
);
    typedef struct packed {
        logic [TRIP_W-1:0] det_sel;
        logic [TRIP_W-1:0] warn_sel;
    } por_st_t;

    localparam chip_st_t CHIP_RST = '{re: 1'b1, default: '0};

    logic rst_chip_n;
    assign rst_chip_n = por_n & chip_rst_n;

    logic wr_det, wr_warn, wr_reg;
    assign wr_det  = bus_wr && (bus_addr == A_DET);
    assign wr_warn = bus_wr && (bus_addr == A_WARN);
    assign wr_reg  = bus_wr && (bus_addr == A_REG);

    por_st_t  por_d, por_q;
    chip_st_t chip_d, chip_q;

    // ---- next state ----
    always_comb begin
        por_d = por_q;
        if (wr_det)  por_d.det_sel  = bus_wdata[TRIP_W-1:0];
        if (wr_warn) por_d.warn_sel = bus_wdata[TRIP_W-1:0];
    end

    always_comb begin
        chip_d = chip_q;
        if (wr_det) begin
            chip_d.ie[CH_DET] = bus_wdata[B_IE];
            chip_d.re_locked  = 1'b1;
            if (!chip_q.re_locked) chip_d.re = bus_wdata[B_RE];
        end
        if (wr_warn) chip_d.ie[CH_WRN] = bus_wdata[B_IE];
        if (wr_reg) begin
            chip_d.bgbuf = bus_wdata[B_BUF];
            chip_d.bglp  = bus_wdata[B_BGLP];
            if (bus_wdata[B_ISO]) chip_d.iso = 1'b0;
        end
        if (iso_set) chip_d.iso = 1'b1;
    end

    // ---- registers, one per reset domain ----
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) por_q <= '0;
        else        por_q <= por_d;
    end

    always_ff @(posedge clk or negedge rst_chip_n) begin
        if (!rst_chip_n) chip_q <= CHIP_RST;
        else             chip_q <= chip_d;
    end

    // ---- event flags ----
    logic [NCH-1:0] below_v, ack_v, flag_v;
    assign below_v[CH_DET] = det_below;
    assign below_v[CH_WRN] = warn_below;
    assign ack_v[CH_DET]   = wr_det  && bus_wdata[B_ACK];
    assign ack_v[CH_WRN]   = wr_warn && bus_wdata[B_ACK];

    for (genvar g = 0; g < NCH; g++) begin : g_flag
        lvd_flag_cell i_cell (
            .clk   (clk),
            .rst_n (rst_chip_n),
            .below (below_v[g]),
            .block (lowpwr_mode),
            .ack   (ack_v[g]),
            .flag  (flag_v[g])
        );
    end

    logic det_flag, warn_flag, det_rst_en, rst_en_locked;
    logic [NCH-1:0] irq_en;
    assign det_flag      = flag_v[CH_DET];
    assign warn_flag     = flag_v[CH_WRN];
    assign det_rst_en    = chip_q.re;
    assign rst_en_locked = chip_q.re_locked;
    assign irq_en        = chip_q.ie;

    lvd_readback #(.TRIP_W(TRIP_W)) i_rb (
        .addr     (bus_addr),
        .det_sel  (por_q.det_sel),
        .warn_sel (por_q.warn_sel),
        .flag     (flag_v),
        .st       (chip_q),
        .run_stat (reg_run_stat),
        .rdata    (bus_rdata)
    );

    // ---- outputs ----
    assign det_trip_sel  = por_q.det_sel;
    assign warn_trip_sel = por_q.warn_sel;
    assign det_irq       = det_flag  & chip_q.ie[CH_DET];
    assign warn_irq      = warn_flag & chip_q.ie[CH_WRN];
    assign lvd_reset_req = det_flag  & chip_q.re;
    assign bgbuf_en      = chip_q.bgbuf;
    assign bg_lp_en      = chip_q.bglp;
    assign io_iso        = chip_q.iso;
endmodule

// File: rtl/lvd_ctrl_regs_chk.sv
module lvd_ctrl_regs_chk (
    input logic       clk,
    input logic       por_n,
    input logic       chip_rst_n,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic       det_below,
    input logic       lowpwr_mode,
    input logic       iso_set,
    input logic       det_flag,
    input logic       det_rst_en,
    input logic       rst_en_locked,
    input logic [1:0] irq_en,
    input logic       det_irq,
    input logic       io_iso
);
    logic rst_any;
    assign rst_any = !por_n || !chip_rst_n;

    // once locked, the reset enable does not move
    assert_re_locked_R2: assert property (@(posedge clk) disable iff (rst_any)
        rst_en_locked |=> $stable(det_rst_en));

    // acknowledge without a new low-supply level clears the detect flag
    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (rst_any)
        (bus_wr && bus_addr == 2'd0 && bus_wdata[6] && !det_below) |=> !det_flag);

    // an interrupt never appears without its enable
    assert_irq_needs_en_R4: assert property (@(posedge clk) disable iff (rst_any)
        det_irq |-> irq_en[0]);

    // low-power mode keeps a clear flag clear
    assert_lowpwr_blocks_R7: assert property (@(posedge clk) disable iff (rst_any)
        (lowpwr_mode && !det_flag) |=> !det_flag);

    // an isolation pulse always leaves isolation held
    assert_iso_set_R9: assert property (@(posedge clk) disable iff (rst_any)
        iso_set |=> io_iso);
endmodule

bind lvd_ctrl_regs lvd_ctrl_regs_chk i_chk (
    .clk           (clk),
    .por_n         (por_n),
    .chip_rst_n    (chip_rst_n),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .det_below     (det_below),
    .lowpwr_mode   (lowpwr_mode),
    .iso_set       (iso_set),
    .det_flag      (det_flag),
    .det_rst_en    (det_rst_en),
    .rst_en_locked (rst_en_locked),
    .irq_en        (irq_en),
    .det_irq       (det_irq),
    .io_iso        (io_iso)
);

// File: tb/test_lvd_ctrl_regs.sv
`timescale 1ns/1ps
module test_lvd_ctrl_regs;
    logic       clk = 0;
    logic       por_n = 0, chip_rst_n = 0;
    logic [1:0] bus_addr = 0;
    logic       bus_wr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       det_below = 0, warn_below = 0, lowpwr_mode = 0;
    logic       reg_run_stat = 1, iso_set = 0;
    logic [1:0] det_trip_sel, warn_trip_sel;
    logic       det_irq, warn_irq, lvd_reset_req, bgbuf_en, bg_lp_en, io_iso;

    int checks = 0, errors = 0;
    logic done = 0;

    always #10 clk = ~clk;   // 50 MHz

    lvd_ctrl_regs i_lvd_ctrl_regs (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic do_reset(input logic por);
        @(negedge clk);
        if (por) por_n = 0;
        chip_rst_n = 0;
        repeat (2) @(negedge clk);
        por_n = 1; chip_rst_n = 1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset(1);
        rd(0, v); chk("R1 byte0", v, 8'h10);
        rd(1, v); chk("R1 byte1", v, 8'h00);
        rd(2, v); chk("R1 byte2", v, 8'h04);
        rd(3, v); chk("R11 addr3", v, 8'h00);
        chk("R1 outputs", {4'b0, det_irq, warn_irq, lvd_reset_req, io_iso}, 8'h00);
    endtask

    task automatic t_write_once();
        logic [7:0] v;
        wr(0, 8'h00);
        rd(0, v); chk("R2 first write clears RE", v, 8'h00);
        wr(0, 8'h13);
        rd(0, v); chk("R2 second write ignored for RE", v, 8'h03);
        chk("R5 det trip out", {6'b0, det_trip_sel}, 8'h03);
    endtask

    task automatic t_warn_irq();
        logic [7:0] v;
        wr(1, 8'h22);
        chk("R5 warn trip out", {6'b0, warn_trip_sel}, 8'h02);
        @(negedge clk) warn_below = 1;
        @(negedge clk);
        rd(1, v); chk("R6 warn flag set", v, 8'hA2);
        chk("R4 warn irq", {7'b0, warn_irq}, 8'h01);
        wr(1, 8'h62);
        rd(1, v); chk("R3 ack clears, reads 0", v, 8'h22);
        chk("R4 warn irq low", {7'b0, warn_irq}, 8'h00);
        @(negedge clk);
        rd(1, v); chk("R6 held level no reset", v, 8'h22);
        warn_below = 0;
    endtask

    task automatic t_chip_reset_req();
        logic [7:0] v;
        do_reset(0);
        rd(0, v); chk("R5 det sel kept over chip reset", v, 8'h13);
        rd(1, v); chk("R5 warn sel kept over chip reset", v, 8'h02);
        @(negedge clk) det_below = 1;
        @(negedge clk);
        chk("R4 reset request", {7'b0, lvd_reset_req}, 8'h01);
        chk("R4 det irq off", {7'b0, det_irq}, 8'h00);
        wr(0, 8'h53);
        chk("R3 reset request cleared", {7'b0, lvd_reset_req}, 8'h00);
        rd(0, v); chk("R3 det ack", v, 8'h13);
        det_below = 0;
        do_reset(1);
        rd(0, v); chk("R5 por clears det sel", v, 8'h10);
        rd(1, v); chk("R5 por clears warn sel", v, 8'h00);
    endtask

    task automatic t_level_at_reset();
        logic [7:0] v;
        @(negedge clk) det_below = 1;
        do_reset(0);
        @(negedge clk);
        rd(0, v); chk("R6 level at reset exit", v, 8'h90);
        wr(0, 8'h50);
        det_below = 0;
    endtask

    task automatic t_lowpwr();
        logic [7:0] v;
        @(negedge clk) lowpwr_mode = 1; warn_below = 1;
        repeat (2) @(negedge clk);
        rd(1, v); chk("R7 no set in low power", v, 8'h00);
        lowpwr_mode = 0;
        @(negedge clk);
        rd(1, v); chk("R7 edge not remembered", v, 8'h00);
        warn_below = 0;
        @(negedge clk) warn_below = 1;
        @(negedge clk);
        rd(1, v); chk("R7 sets again after exit", v, 8'h80);
        wr(1, 8'h40);
        warn_below = 0;
    endtask

    task automatic t_race();
        logic [7:0] v;
        @(negedge clk);
        det_below = 1; bus_addr = 0; bus_wdata = 8'h40; bus_wr = 1;
        @(negedge clk) bus_wr = 0;
        rd(0, v); chk("R10 event wins over ack", v[7:0] & 8'h80, 8'h80);
        wr(0, 8'h40);
        det_below = 0;
    endtask

    task automatic t_reserved();
        logic [7:0] v;
        wr(1, 8'hBF);
        rd(1, v); chk("R11 warn reserved zero", v, 8'h23);
        wr(3, 8'hFF);
        rd(3, v); chk("R11 addr3 zero", v, 8'h00);
    endtask

    task automatic t_regulator();
        logic [7:0] v;
        wr(2, 8'hF7);
        rd(2, v); chk("R8 reg byte", v, 8'h15);
        chk("R8 outputs", {6'b0, bgbuf_en, bg_lp_en}, 8'h03);
        reg_run_stat = 0;
        rd(2, v); chk("R8 run status follows", v, 8'h11);
        @(negedge clk) iso_set = 1;
        @(negedge clk) iso_set = 0;
        rd(2, v); chk("R9 iso set", v, 8'h19);
        chk("R9 iso out", {7'b0, io_iso}, 8'h01);
        wr(2, 8'h11);
        chk("R9 write 0 keeps iso", {7'b0, io_iso}, 8'h01);
        wr(2, 8'h08);
        rd(2, v); chk("R9 iso cleared", v, 8'h00);
        chk("R8 outputs off", {6'b0, bgbuf_en, bg_lp_en}, 8'h00);
        reg_run_stat = 1;
    endtask

    initial begin
        t_reset();
        t_write_once();
        t_warn_irq();
        t_chip_reset_req();
        t_level_at_reset();
        t_lowpwr();
        t_race();
        t_reserved();
        t_regulator();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule